// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block is the word-address register inside a small serial non-volatile memory. It is loaded with a new word address when the protocol engine has received an address byte, and it steps forward by one location after each data byte moves over the bus. The same register serves writes and reads, but the two use different step rules. A write step advances only the offset bits inside the current page, so a long burst circles inside one page and overwrites the bytes it wrote earlier. A read step advances the whole address, so a long read runs across page edges and wraps from the top of the array back to location zero.

One parameter selects the storage density, from 1 Kbit to 16 Kbit. This sets the address width (7 to 11 bits) and the page size (8 or 16 bytes). At the larger densities, the high bits of a loaded address come from page-select bits that the protocol engine takes from the device-address byte. These bits sit directly above the received address byte. Between operations the register keeps its value, which is one past the last location accessed. A following read with no address can therefore pick up where the last transfer stopped.

Top module: `page_addr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cur_addr` becomes 0.
- R2: A load forms the 11-bit value {`page_sel`[2:0], `word_byte`[7:0]} and keeps only its low AW bits, where AW = 7 + `DENSITY_CODE`. `page_sel` bit 0 lands directly above `word_byte` bit 7. The 1 Kbit part (code 0) drops `word_byte` bit 7 and all page bits. The 16 Kbit part (code 4) keeps all three page bits.
- R3: A write step adds one to the low OW bits of the address and leaves the upper AW-OW bits unchanged. OW is 3 for codes 0 and 1 and 4 for codes 2 to 4.
- R4: A write step from the last offset of a page (all OW low bits set) goes to offset 0 of the same page. 2^OW write steps bring the address back to where it started.
- R5: A read step adds one to the whole AW-bit address and carries across page boundaries.
- R6: A read step from the all-ones address goes to 0.
- R7: With `load_en`, `wr_step` and `rd_step` all low, `cur_addr` keeps its value whatever `page_sel` and `word_byte` carry.
- R8: When more than one request is high in a cycle, a load wins over a write step, and a write step wins over a read step.
- R9: A request sampled at a rising edge appears on `cur_addr` just after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load a new address from `page_sel` and `word_byte` |
| page_sel | input | 3 | Page-select bits taken from the device-address byte |
| word_byte | input | 8 | Received word-address byte |
| wr_step | input | 1 | Advance after a written data byte (in-page wrap) |
| rd_step | input | 1 | Advance after a read data byte (whole-array wrap) |
| cur_addr | output | AW | Current word address, AW = 7 + `DENSITY_CODE` |

## Verification
The bench builds two copies from the same stimulus. One uses the 16 Kbit setting (11-bit address, 16-byte pages, three page bits). The other uses the 1 Kbit setting (7-bit address, 8-byte pages, no page bits, `word_byte` bit 7 dropped). Because the two copies share every input, each burst shows both page sizes and both array-top wraps side by side. This covers the case where the same load value is truncated differently, the in-page wrap at offset 7 against offset 15, and the read wrap from 127 and from 2047.

// File: rtl/pgctr_pkg.sv
package pgctr_pkg;

    localparam int WORD_BYTE_W   = 8;
    localparam int PAGE_SEL_W    = 3;
    localparam int MAX_CODE      = 4;

    // Kind of update applied to the address register in one cycle
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_LOAD   = 2'd1,
        UPD_PAGE   = 2'd2,
        UPD_LINEAR = 2'd3
    } upd_e;

    // Raw load request as delivered by the protocol engine
    typedef struct packed {
        logic [PAGE_SEL_W-1:0]  page;
        logic [WORD_BYTE_W-1:0] word;
    } load_req_t;

    // Address width for a density code (0 = 1 Kbit ... 4 = 16 Kbit)
    function automatic int addr_width(input int code);
        return 7 + code;
    endfunction

    // Number of in-page offset bits for a density code
    function automatic int offset_width(input int code);
        return (code < 2) ? 3 : 4;
    endfunction

endpackage

// File: rtl/pgctr_arb.sv
module pgctr_arb
    import pgctr_pkg::*;
(
    input  logic load_en,
    input  logic wr_step,
    input  logic rd_step,
    output upd_e kind
);
    always_comb begin
        if (load_en)      kind = UPD_LOAD;
        else if (wr_step) kind = UPD_PAGE;
        else if (rd_step) kind = UPD_LINEAR;
        else              kind = UPD_HOLD;
    end
endmodule

// File: rtl/pgctr_merge.sv
module pgctr_merge
    import pgctr_pkg::*;
#(
    parameter int AW = 11
) (
    input  load_req_t         req,
    output logic [AW-1:0]     value
);
    localparam int FULL_W = PAGE_SEL_W + WORD_BYTE_W;

    logic [FULL_W-1:0] full;

    assign full = {req.page, req.word};

    generate
        if (AW <= FULL_W) begin : g_trunc
            assign value = full[AW-1:0];
        end else begin : g_extend
            assign value = {{(AW-FULL_W){1'b0}}, full};
        end
    endgenerate
endmodule

// File: rtl/pgctr_next.sv
module pgctr_next #(
    parameter int AW = 11,
    parameter int OW = 4
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] page_next,
    output logic [AW-1:0] lin_next
);
    logic [OW-1:0] off_inc;

    assign off_inc  = cur[OW-1:0] + 1'b1;
    assign lin_next = cur + 1'b1;

    generate
        if (OW < AW) begin : g_paged
            assign page_next = {cur[AW-1:OW], off_inc};
        end else begin : g_flat
            assign page_next = off_inc;
        end
    endgenerate
endmodule

// File: rtl/page_addr_counter.sv
module page_addr_counter
    import pgctr_pkg::*;
#(
    parameter int DENSITY_CODE = 4,
    localparam int AW = addr_width(DENSITY_CODE),
    localparam int OW = offset_width(DENSITY_CODE)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_en,
    input  logic [PAGE_SEL_W-1:0]  page_sel,
    input  logic [WORD_BYTE_W-1:0] word_byte,
    input  logic                   wr_step,
    input  logic                   rd_step,
    output logic [AW-1:0]          cur_addr
);
    upd_e          kind;
    load_req_t     req;
    logic [AW-1:0] load_val;
    logic [AW-1:0] page_nx;
    logic [AW-1:0] lin_nx;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] addr_q;

    assign req.page = page_sel;
    assign req.word = word_byte;

    pgctr_arb u_arb (
        .load_en (load_en),
        .wr_step (wr_step),
        .rd_step (rd_step),
        .kind    (kind)
    );

    pgctr_merge #(.AW(AW)) u_merge (
        .req   (req),
        .value (load_val)
    );

    pgctr_next #(.AW(AW), .OW(OW)) u_next (
        .cur       (addr_q),
        .page_next (page_nx),
        .lin_next  (lin_nx)
    );

    always_comb begin
        unique case (kind)
            UPD_LOAD:   addr_d = load_val;
            UPD_PAGE:   addr_d = page_nx;
            UPD_LINEAR: addr_d = lin_nx;
            default:    addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign cur_addr = addr_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (cur_addr == '0));

    // R3
    page_row_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_step && !load_en) |=> (cur_addr[AW-1:OW] == $past(cur_addr[AW-1:OW])));

    // R4
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_step && !load_en && (&cur_addr[OW-1:0])) |=> (cur_addr[OW-1:0] == '0));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_step && !wr_step && !load_en) |=> (cur_addr == AW'($past(cur_addr) + 1'b1)));

    // R6
    array_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_step && !wr_step && !load_en && (&cur_addr)) |=> (cur_addr == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !wr_step && !rd_step) |=> $stable(cur_addr));

    // R2
    load_low_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cur_addr[OW-1:0] == $past(word_byte[OW-1:0])));
endmodule

// File: tb/sim_page_addr_counter.sv
module sim_page_addr_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [2:0]  page_sel = '0;
    logic [7:0]  word_byte = '0;
    logic        wr_step = 1'b0;
    logic        rd_step = 1'b0;
    logic [10:0] a16;
    logic [6:0]  a1;

    int total = 0;
    int bad = 0;
    int e16 = 0;
    int e1 = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    page_addr_counter u0 (
        .clk(clk), .rst(rst), .load_en(load_en), .page_sel(page_sel),
        .word_byte(word_byte), .wr_step(wr_step), .rd_step(rd_step),
        .cur_addr(a16)
    );

    page_addr_counter #(.DENSITY_CODE(0)) u1 (
        .clk(clk), .rst(rst), .load_en(load_en), .page_sel(page_sel),
        .word_byte(word_byte), .wr_step(wr_step), .rd_step(rd_step),
        .cur_addr(a1)
    );

    // Expected next address from the requirements (code: 0 = 1K .. 4 = 16K)
    function automatic int model(input int code, input int cur, input bit ld,
                                 input int pg, input int wd, input bit wi, input bit ri);
        int aw = 7 + code;
        int ow = (code < 2) ? 3 : 4;
        int mask = (1 << aw) - 1;
        int omask = (1 << ow) - 1;
        if (ld) return ((pg << 8) | wd) & mask;
        if (wi) return (cur & ~omask) | ((cur + 1) & omask);
        if (ri) return (cur + 1) & mask;
        return cur;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h exp=%0h", req, what, got, exp);
        end
    endtask

    task automatic drive(input bit ld, input int pg, input int wd,
                         input bit wi, input bit ri, input string req);
        @(negedge clk);
        load_en = ld; page_sel = pg[2:0]; word_byte = wd[7:0];
        wr_step = wi; rd_step = ri;
        e16 = model(4, e16, ld, pg, wd, wi, ri);
        e1  = model(0, e1, ld, pg, wd, wi, ri);
        @(negedge clk);
        chk(req, "16K", int'(a16), e16);
        chk(req, "1K", int'(a1), e1);
        load_en = 1'b0; wr_step = 1'b0; rd_step = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); load_en = 1'b1; page_sel = 3'd7; word_byte = 8'hFF;
        @(negedge clk);
        chk("R1", "16K reset", int'(a16), 0);
        chk("R1", "1K reset", int'(a1), 0);
        load_en = 1'b0; rst = 1'b0;
        e16 = 0; e1 = 0;
    endtask

    task automatic t_load;
        drive(1, 5, 8'h3F, 0, 0, "R2");
        chk("R2", "16K page merge", int'(a16), 'h53F);
        chk("R2", "1K drops high bits", int'(a1), 'h3F);
        drive(1, 7, 8'hFF, 0, 0, "R2");
        chk("R2", "16K all ones", int'(a16), 'h7FF);
        chk("R2", "1K bit7 dropped", int'(a1), 'h7F);
    endtask

    task automatic t_write_wrap;
        drive(0, 0, 0, 1, 0, "R4");
        chk("R4", "16K in-page wrap", int'(a16), 'h7F0);
        chk("R4", "1K in-page wrap", int'(a1), 'h78);
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 1, 0, "R3");
        chk("R3", "16K offset advance", int'(a16), 'h7F3);
        chk("R3", "1K offset advance", int'(a1), 'h7B);
        drive(1, 2, 8'h4A, 0, 0, "R2");
        for (int i = 0; i < 16; i++) drive(0, 0, 0, 1, 0, "R4");
        chk("R4", "16K full loop", int'(a16), 'h24A);
        chk("R4", "1K two loops", int'(a1), 'h4A);
    endtask

    task automatic t_read_wrap;
        drive(1, 7, 8'hFF, 0, 0, "R2");
        drive(0, 0, 0, 0, 1, "R6");
        chk("R6", "16K array wrap", int'(a16), 0);
        chk("R6", "1K array wrap", int'(a1), 0);
        drive(0, 0, 0, 0, 1, "R5");
        drive(1, 2, 8'h0F, 0, 0, "R2");
        drive(0, 0, 0, 0, 1, "R5");
        chk("R5", "16K crosses page", int'(a16), 'h210);
        chk("R5", "1K crosses page", int'(a1), 'h10);
    endtask

    task automatic t_hold;
        for (int i = 0; i < 4; i++) drive(0, i, 8'hA5 + i, 0, 0, "R7");
        chk("R7", "16K held", int'(a16), 'h210);
        chk("R7", "1K held", int'(a1), 'h10);
    endtask

    task automatic t_priority;
        drive(1, 1, 8'h2F, 1, 1, "R8");
        chk("R8", "16K load wins", int'(a16), 'h12F);
        chk("R8", "1K load wins", int'(a1), 'h2F);
        drive(0, 0, 0, 1, 1, "R8");
        chk("R8", "16K write beats read", int'(a16), 'h120);
        chk("R8", "1K write beats read", int'(a1), 'h28);
    endtask

    task automatic t_timing;
        @(negedge clk); rd_step = 1'b1;
        #3;
        chk("R9", "16K before edge", int'(a16), 'h120);
        chk("R9", "1K before edge", int'(a1), 'h28);
        @(negedge clk); rd_step = 1'b0;
        chk("R9", "16K after edge", int'(a16), 'h121);
        chk("R9", "1K after edge", int'(a1), 'h29);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_load();
        t_write_wrap();
        t_read_wrap();
        t_hold();
        t_priority();
        t_timing();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule